// File: doc/BRIEF.md
# Multi-purpose Pin and Interrupt Router

This block is the local interrupt, power-down and wake-event logic of a peripheral device that presents two functions to its host: function 0 holds two UARTs and function 1 holds a parallel port. It owns two multi-purpose pins. Each pin can be an input, taken straight or inverted, or an output that drives a fixed level. Every input pin is routed to one of the two functions. A routed pin can add to that function's interrupt, signal a power-down request or set a wake (PME) status bit.

The block merges the UART interrupt lines, the parallel-port interrupt and the pin events into one interrupt output per function, each source under its own mask. A function 0 power-down request is raised only when both UARTs, and every pin routed to function 0 with power-down enabled, have asked for power-down without a break for a whole filter period. The period is counted in one-second ticks that come from outside the block. A pin routed to function 1 raises that function's request at once. The power-down and PME status bits stay set until the status word is read.

Software reaches the block through a 32-bit register port with a write strobe, a read strobe and a word address. Word 0 is the control word and word 1 is the status word. Reading the status word clears its sticky bits.

Top module: `mio_irq_router`

## Requirements
- R1: Pin i is configured by control bits [2i+1:2i]. Code 00 is a straight input and code 01 an inverted input; in both, pin_oe[i] is 0 and pin_out[i] is 0. Code 10 drives pin_out[i]=0 with pin_oe[i]=1. Code 11 drives pin_out[i]=1 with pin_oe[i]=1.
- R2: Status bits [4:3] give the state of pins 1:0 after the optional inversion. The state is resynchronised through two register stages. A pin is active when it is in an input mode and its state is 1.
- R3: After reset the control word reads 0x0001C0C0: both pins straight inputs, filter disabled, both function selects set, UART and parallel-port interrupt enables set, and every other field 0.
- R4: Status bits [1:0] are the inverse of bit 0 of each UART's interrupt source register (input uart_src_b0). irq_f0 is raised by each of these bits that has its enable set in control bits [15:14].
- R5: Status bit 2 follows pp_irq. irq_f1 is raised by it when control bit 16 is set.
- R6: An active pin with its interrupt mask bit set (control bits [9:8]) raises irq_f1 when its function-select bit (control bits [7:6]) is 1, and raises irq_f0 when that bit is 0.
- R7: The power-down status bits (status [6:5], function 1:0) and the PME status bits (status [8:7], function 1:0) are sticky. A status read clears them. A set event in the same cycle as the read wins, and the bit stays 1.
- R8: The function 0 filter period code is in control bits [5:4]: 00 disabled, 01 = 4 ticks, 10 = 129 ticks, 11 = 515 ticks. The function 0 condition is that uart_pd is 11 and every pin routed to function 0 with its power-down mask set (control bits [11:10]) is active. pd_req[0] pulses once for one cycle after the tick that completes the period with the condition held, and it sets status bit 5.
- R9: If the function 0 condition drops, the filter count restarts from zero.
- R10: When a pin routed to function 1 with its power-down mask set becomes active, pd_req[1] pulses for one cycle at once, with no filtering, and status bit 6 is set.
- R11: When a pin with its PME enable set (control bits [13:12]) becomes active, pme_req pulses for the function the pin is routed to, and that function's PME status bit is set.
- R12: Control bits [18:17] let the power-down status bit of function 1:0 raise that function's interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per filter time unit |
| pin_in | input | 2 | Pad input values of the multi-purpose pins |
| pin_out | output | 2 | Pad output values |
| pin_oe | output | 2 | Pad output enables |
| uart_src_b0 | input | 2 | Bit 0 of each UART interrupt source register (1 = nothing pending) |
| uart_pd | input | 2 | Power-down indication of each UART |
| pp_irq | input | 1 | Parallel-port interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address (0 control, 1 status) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| irq_f0 | output | 1 | Function 0 interrupt |
| irq_f1 | output | 1 | Function 1 interrupt |
| pd_req | output | 2 | Power-down request pulses, function 1:0 |
| pme_req | output | 2 | PME request pulses, function 1:0 |

## Verification
A wrong function-select or mask bit shows up within one cycle as an interrupt on the wrong function output. A pin state held in the wrong synchroniser stage shows up as a status read or an event pulse two cycles late or early. A filter count that does not restart, or that ends one tick off, shows up as a pd_req[0] pulse on the wrong tick. The bench therefore checks the pulse count on both sides of the completing tick. A sticky bit that clears when a set arrives in the same cycle shows up on the very next status read.

// File: rtl/mio_pkg.sv
// Shared sizes, pin mode codes and control word layout of the router.
// Assumes two functions; pin and UART counts are package parameters.
package mio_pkg;
    localparam int NPIN  = 2;
    localparam int NUART = 2;
    localparam int DW    = 32;
    localparam int AW    = 2;

    typedef enum logic [1:0] {
        PIN_IN     = 2'b00,
        PIN_IN_INV = 2'b01,
        PIN_DRV0   = 2'b10,
        PIN_DRV1   = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic [1:0]        pd_irq_en;  // 18:17
        logic              pp_en;      // 16
        logic [NUART-1:0]  uart_en;    // 15:14
        logic [NPIN-1:0]   pme_en;     // 13:12
        logic [NPIN-1:0]   pd_mask;    // 11:10
        logic [NPIN-1:0]   int_mask;   // 9:8
        logic [NPIN-1:0]   fsel;       // 7:6
        logic [1:0]        period;     // 5:4
        logic [2*NPIN-1:0] pin_cfg;    // 3:0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int STAT_W = NUART + 1 + NPIN + 2 + 2;

    localparam ctrl_t CTRL_RST = '{
        pd_irq_en: 2'b00, pp_en: 1'b1, uart_en: {NUART{1'b1}},
        pme_en: '0, pd_mask: '0, int_mask: '0, fsel: {NPIN{1'b1}},
        period: 2'b00, pin_cfg: '0
    };

    localparam logic [AW-1:0] ADDR_CTRL = AW'(0);
    localparam logic [AW-1:0] ADDR_STAT = AW'(1);
endpackage

// File: rtl/mio_pin_cell.sv
// One multi-purpose pin: mode decode, output drive and two-stage input
// resynchronisation with optional inversion.
// Assumes pin_in is asynchronous to clk; the state lags it by two edges.
module mio_pin_cell
    import mio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  logic [1:0] cfg,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       state,
    output logic       active
);
    pin_mode_e mode;
    logic      sync1, sync2;

    assign mode = pin_mode_e'(cfg);

    // Two-flop resynchroniser for the pad input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= pin_in;
            sync2 <= sync1;
        end
    end

    // Mode decode: output drive and the internal state after inversion.
    always_comb begin
        pin_oe  = (mode == PIN_DRV0) || (mode == PIN_DRV1);
        pin_out = (mode == PIN_DRV1);
        state   = sync2 ^ (mode == PIN_IN_INV);
        active  = state && !pin_oe;
    end
endmodule

// File: rtl/mio_pd_filter.sv
// Power-down qualifying timer: counts ticks while the condition holds and
// emits one pulse when the selected period completes.
// Assumes tick is a one-cycle pulse; code 00 keeps the timer idle.
module mio_pd_filter #(
    parameter int P1 = 4,
    parameter int P2 = 129,
    parameter int P3 = 515
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] code,
    input  logic       cond,
    output logic       req
);
    localparam int CW = $clog2(P3 + 1);

    logic [CW-1:0] cnt, limit, cnt_nxt;
    logic          fired, done;

    // Period selection from the 2-bit code.
    always_comb begin
        unique case (code)
            2'b01:   limit = CW'(P1);
            2'b10:   limit = CW'(P2);
            2'b11:   limit = CW'(P3);
            default: limit = '0;
        endcase
        cnt_nxt = cnt + CW'(1);
        done    = cond && (code != 2'b00) && tick && !fired && (cnt_nxt == limit);
    end

    // Tick counter, restarted whenever the condition drops or is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (!cond || code == 2'b00) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (done) begin
            cnt   <= '0;
            fired <= 1'b1;
        end else if (tick && !fired) begin
            cnt   <= cnt_nxt;
        end
    end

    // Registered one-cycle request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= done;
    end
endmodule

// File: rtl/mio_sticky.sv
// Vector of sticky status bits: set by events, cleared by a read strobe,
// with a set arriving together with the clear taking priority.
module mio_sticky #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] q
);
    // Set-over-clear update.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= set | (q & ~{W{clr}});
    end
endmodule

// File: rtl/mio_irq_router.sv
// Top of the pin and interrupt router: control register, pin cells,
// function routing, function 0 filter and sticky status.
// Assumes a single-cycle register port; reading status clears sticky bits.
module mio_irq_router
    import mio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic [NPIN-1:0]  pin_in,
    output logic [NPIN-1:0]  pin_out,
    output logic [NPIN-1:0]  pin_oe,
    input  logic [NUART-1:0] uart_src_b0,
    input  logic [NUART-1:0] uart_pd,
    input  logic             pp_irq,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq_f0,
    output logic             irq_f1,
    output logic [1:0]       pd_req,
    output logic [1:0]       pme_req
);
    ctrl_t             ctrl;
    logic [NPIN-1:0]   state, active, act_q, rise;
    logic [NUART-1:0]  uart_stat;
    logic [1:0]        pd_set, pme_set, pd_st, pme_st;
    logic              f0_cond, filt_req, stat_rd;
    logic [STAT_W-1:0] status;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[DW-1:CTRL_W];

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ctrl <= CTRL_RST;
        else if (reg_wr && reg_addr == ADDR_CTRL) ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    // One cell per multi-purpose pin.
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        mio_pin_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_in (pin_in[i]),
            .cfg    (ctrl.pin_cfg[2*i +: 2]),
            .pin_out(pin_out[i]),
            .pin_oe (pin_oe[i]),
            .state  (state[i]),
            .active (active[i])
        );
    end

    // Previous active level, for event edges.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= active;
    end

    // Event detection and routing of pin events to the two functions.
    always_comb begin
        rise       = active & ~act_q;
        uart_stat  = ~uart_src_b0;
        f0_cond    = (&uart_pd) && (&(active | ~(ctrl.pd_mask & ~ctrl.fsel)));
        pd_set[1]  = |(rise & ctrl.pd_mask & ctrl.fsel);
        pd_set[0]  = filt_req;
        pme_set[1] = |(rise & ctrl.pme_en & ctrl.fsel);
        pme_set[0] = |(rise & ctrl.pme_en & ~ctrl.fsel);
    end

    mio_pd_filter u_filter (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (sec_tick),
        .code (ctrl.period),
        .cond (f0_cond),
        .req  (filt_req)
    );

    assign stat_rd = reg_rd && (reg_addr == ADDR_STAT);

    mio_sticky #(.W(2)) u_pd_st (
        .clk(clk), .rst_n(rst_n), .set(pd_set), .clr(stat_rd), .q(pd_st)
    );

    mio_sticky #(.W(2)) u_pme_st (
        .clk(clk), .rst_n(rst_n), .set(pme_set), .clr(stat_rd), .q(pme_st)
    );

    // Interrupt merge per function.
    always_comb begin
        irq_f0 = |(uart_stat & ctrl.uart_en)
               | |(active & ctrl.int_mask & ~ctrl.fsel)
               | (pd_st[0] & ctrl.pd_irq_en[0]);
        irq_f1 = (pp_irq & ctrl.pp_en)
               | |(active & ctrl.int_mask & ctrl.fsel)
               | (pd_st[1] & ctrl.pd_irq_en[1]);
        pd_req  = pd_set;
        pme_req = pme_set;
    end

    // Status word assembly and read multiplexer.
    always_comb begin
        status = {pme_st, pd_st, state, pp_irq, uart_stat};
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == ADDR_CTRL)      reg_rdata = DW'(ctrl);
            else if (reg_addr == ADDR_STAT) reg_rdata = DW'(status);
        end
    end
endmodule

// File: rtl/mio_router_chk.sv
// Property checker for the router, attached to every instance by bind.
module mio_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] pin_cfg,
    input logic [1:0] pin_out,
    input logic [1:0] pin_oe,
    input logic       reg_rd,
    input logic [1:0] reg_addr,
    input logic [1:0] pd_set,
    input logic [1:0] pd_st,
    input logic [1:0] period,
    input logic [1:0] pd_req
);
    a_r1_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cfg[1:0] == 2'b11) |-> (pin_oe[0] && pin_out[0]));

    a_r1_input_released: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_cfg[3] |-> (!pin_oe[1] && !pin_out[1]));

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd1 && !pd_set[1]) |=> !pd_st[1]);

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pd_set[1] |=> pd_st[1]);

    a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (period == 2'b00) |=> !pd_req[0]);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req[0] |=> !pd_req[0]);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req[1] |=> !pd_req[1]);
endmodule

bind mio_irq_router mio_router_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_cfg (ctrl.pin_cfg),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .reg_rd  (reg_rd),
    .reg_addr(reg_addr),
    .pd_set  (pd_set),
    .pd_st   (pd_st),
    .period  (ctrl.period),
    .pd_req  (pd_req)
);

// File: tb/test_mio_irq_router.sv
`timescale 1ns/1ps
module test_mio_irq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [1:0]  pin_in = 2'b00;
    logic [1:0]  pin_out, pin_oe;
    logic [1:0]  uart_src_b0 = 2'b11;
    logic [1:0]  uart_pd = 2'b00;
    logic        pp_irq = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_f0, irq_f1;
    logic [1:0]  pd_req, pme_req;

    int checks = 0, fails = 0;
    int pd_cnt0 = 0, pd_cnt1 = 0, pme_cnt0 = 0, pme_cnt1 = 0;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    mio_irq_router i_mio_irq_router (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .uart_src_b0(uart_src_b0),
        .uart_pd(uart_pd), .pp_irq(pp_irq), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_f0(irq_f0), .irq_f1(irq_f1), .pd_req(pd_req), .pme_req(pme_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares read data against the queue and counts pulses.
    always @(negedge clk) begin
        if (reg_rd && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            chk(it.tag, reg_rdata & it.mask, it.exp);
        end
        if (pd_req[0])  pd_cnt0++;
        if (pd_req[1])  pd_cnt1++;
        if (pme_req[0]) pme_cnt0++;
        if (pme_req[1]) pme_cnt1++;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp,
                      input logic [31:0] mask, input string tag);
        item_t it;
        it.exp = exp; it.mask = mask; it.tag = tag;
        exp_q.push_back(it);
        reg_rd = 1'b1; reg_addr = a;
        step(1);
        reg_rd = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = v;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            sec_tick = 1'b1;
            step(1);
            sec_tick = 1'b0;
            step(1);
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R3 reset state
        rd(2'd0, 32'h0001C0C0, 32'hFFFFFFFF, "R3 control reset");
        rd(2'd1, 32'h0, 32'h1FF, "R3 status reset");
        chk("R3 irq reset", {30'b0, irq_f1, irq_f0}, 32'h0);
        chk("R1 oe reset", {30'b0, pin_oe}, 32'h0);

        // R4 UART interrupt status and enable
        uart_src_b0 = 2'b10;
        step(1);
        rd(2'd1, 32'h1, 32'h3, "R4 uart status inverse");
        chk("R4 irq_f0 enabled", {31'b0, irq_f0}, 32'h1);
        wr_ctrl(32'h000100C0);
        chk("R4 irq_f0 masked", {31'b0, irq_f0}, 32'h0);
        uart_src_b0 = 2'b11;

        // R5 parallel-port interrupt
        wr_ctrl(32'h0001C0C0);
        pp_irq = 1'b1;
        step(1);
        rd(2'd1, 32'h4, 32'h7, "R5 pp status");
        chk("R5 irq_f1 enabled", {31'b0, irq_f1}, 32'h1);
        wr_ctrl(32'h0000C0C0);
        chk("R5 irq_f1 masked", {31'b0, irq_f1}, 32'h0);
        pp_irq = 1'b0;

        // R1 output drive codes
        wr_ctrl(32'h0001C0CB);
        chk("R1 pin_out", {30'b0, pin_out}, 32'h1);
        chk("R1 pin_oe", {30'b0, pin_oe}, 32'h3);

        // R2 pin state after inversion
        wr_ctrl(32'h0001C0C1);
        pin_in = 2'b00;
        step(3);
        rd(2'd1, 32'h08, 32'h18, "R2 state inverted low");
        chk("R1 inputs released", {30'b0, pin_oe}, 32'h0);
        pin_in = 2'b11;
        step(3);
        rd(2'd1, 32'h10, 32'h18, "R2 state both high");

        // R6 pin interrupt routing
        wr_ctrl(32'h0001C2C1);
        chk("R6 to f1 irq_f1", {31'b0, irq_f1}, 32'h1);
        chk("R6 to f1 irq_f0", {31'b0, irq_f0}, 32'h0);
        wr_ctrl(32'h0001C241);
        chk("R6 to f0 irq_f0", {31'b0, irq_f0}, 32'h1);
        chk("R6 to f0 irq_f1", {31'b0, irq_f1}, 32'h0);

        // R10 R11 R7 R12 pin events on function 1
        pin_in = 2'b00;
        wr_ctrl(32'h0005E8C1);
        step(3);
        rd(2'd1, 32'h0, 32'h1E0, "R7 clear before event");
        pin_in = 2'b10;
        step(2);
        rd(2'd1, 32'h0, 32'h1E0, "R7 read in set cycle");
        chk("R12 pd status raises irq_f1", {31'b0, irq_f1}, 32'h1);
        rd(2'd1, 32'h140, 32'h1E0, "R7 set wins over read");
        chk("R12 irq_f1 after clear", {31'b0, irq_f1}, 32'h0);
        rd(2'd1, 32'h0, 32'h1E0, "R7 cleared by read");
        chk("R10 pd_req f1 pulses", pd_cnt1, 1);
        chk("R11 pme_req f1 pulses", pme_cnt1, 1);
        chk("R11 pme_req f0 pulses", pme_cnt0, 0);

        // R8 function 0 filter, 4-tick period
        pin_in = 2'b00;
        wr_ctrl(32'h0001C0D0);
        uart_pd = 2'b11;
        step(2);
        ticks(3);
        chk("R8 no request before period", pd_cnt0, 0);
        ticks(1);
        chk("R8 request at period", pd_cnt0, 1);
        rd(2'd1, 32'h20, 32'h20, "R8 f0 pd status");

        // R8 a pin routed to function 0 gates the condition
        uart_pd = 2'b00;
        wr_ctrl(32'h0001C490);
        uart_pd = 2'b11;
        step(2);
        ticks(5);
        chk("R8 inactive f0 pin blocks", pd_cnt0, 1);
        pin_in = 2'b01;
        step(3);
        ticks(4);
        chk("R8 active f0 pin allows", pd_cnt0, 2);

        // R9 restart on a break
        uart_pd = 2'b00;
        wr_ctrl(32'h0001C0D0);
        uart_pd = 2'b11;
        step(1);
        ticks(3);
        uart_pd = 2'b01;
        step(1);
        uart_pd = 2'b11;
        step(1);
        ticks(3);
        chk("R9 count restarted", pd_cnt0, 2);
        ticks(1);
        chk("R9 request after full period", pd_cnt0, 3);

        // R8 disabled code
        uart_pd = 2'b00;
        wr_ctrl(32'h0001C0C0);
        uart_pd = 2'b11;
        step(1);
        ticks(6);
        chk("R8 disabled filter", pd_cnt0, 3);

        // R8 129-tick period
        uart_pd = 2'b00;
        wr_ctrl(32'h0001C0E0);
        uart_pd = 2'b11;
        step(1);
        ticks(128);
        chk("R8 129 ticks minus one", pd_cnt0, 3);
        ticks(1);
        chk("R8 129 ticks", pd_cnt0, 4);
        chk("R10 no f1 request from f0", pd_cnt1, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule